// File: doc/BRIEF.md
# Dual-Direction Bus Transceiver Storage Path

This block sits between two 18-bit ports, A and B, and carries data in both directions at once. Each direction owns one storage element. That element works in one of three ways. It follows its source port while its latch enable is high. It keeps its contents while the enable is low and the capture clock holds steady. It loads new data when the capture clock falls while the enable is low. The bidirectional pins are modelled as separate input, output and output-enable vectors. When a direction is switched off, its output data reads zero and its output enable drops.

All logic runs on one fast system clock. The two capture clocks are ordinary sampled inputs, and a falling edge is found by comparing two successive samples. Each port has a drive flag. The flag marks cycles in which an outside agent actually drives that port. While the flag is low, the block keeps using the last driven value, so an idle bus holds its level.

The data path is plain pins with no handshake. Every storage element reacts every cycle and nothing can stall it, so there is no back-pressure to define.

Top module: `ubt_regpath`

## Requirements
- R1: The two directions are independent. A-to-B data flows from the effective A input to `b_out` using only the `ab_*` controls. B-to-A data flows from the effective B input to `a_out` using only the `ba_*` controls. Both paths can carry different 18-bit values in the same cycle.
- R2: While a direction's latch enable is 1, its output shows the effective source value of the same cycle. At the next clock edge the storage loads that value. A capture-clock edge seen in such a cycle makes no difference.
- R3: While the latch enable is 0 and the sampled capture clock stays at a steady 1 or a steady 0, the stored value does not change, whatever the source does.
- R4: With the latch enable at 0, suppose the capture clock is sampled 1 at one edge and 0 at the next edge. Then the storage loads the effective source value at the edge after that. The output does not change before then.
- R5: A 0-to-1 change of the capture clock while the latch enable is 0 loads nothing.
- R6: The A-to-B enable `ab_oe` is active at 1. While it is 0, `b_out_en` is 0 and `b_out` reads all zeros.
- R7: The B-to-A enable `ba_oe_n` is active at 0. While it is 1, `a_out_en` is 0 and `a_out` reads all zeros.
- R8: Turning an output off leaves the stored value unchanged. When the output is turned back on, it shows the same value as before.
- R9: While a port's drive flag (`a_drv` or `b_drv`) is 0, the effective input of that port is the value it had at the last clock edge when the flag was 1.
- R10: A synchronous active-high `rst` clears both storage elements and both held input values to zero. It does not change the output enables, which follow their inputs only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data present on port A |
| a_drv | input | 1 | 1 when port A is driven from outside |
| b_in | input | 18 | Data present on port B |
| b_drv | input | 1 | 1 when port B is driven from outside |
| ab_le | input | 1 | A-to-B latch enable |
| ab_clk | input | 1 | A-to-B capture clock (falling edge loads) |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable |
| ba_clk | input | 1 | B-to-A capture clock (falling edge loads) |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Data driven toward port B |
| b_out_en | output | 1 | 1 when `b_out` drives port B |
| a_out | output | 18 | Data driven toward port A |
| a_out_en | output | 1 | 1 when `a_out` drives port A |

## Verification
The assertions assume that the capture clocks and latch enables are ordinary synchronous inputs, each changing at most once per system cycle. They also assume that a capture clock holds each level for at least one sample before it changes again, so every falling edge is seen. The bench changes inputs only on the falling system edge and moves each capture clock by one level per step. It holds data steady through the capture cycle of R4, so the value that gets loaded is known without doubt. The drive flags are treated as trusted. No check tries to model two sources driving one port.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int UBT_DATA_W = 18;
  localparam int UBT_NDIR   = 2;

  typedef enum logic {
    DIR_AB = 1'b0,
    DIR_BA = 1'b1
  } ubt_dir_e;
endpackage

// File: rtl/ubt_bushold.sv
module ubt_bushold #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pin_in,
  input  logic          pin_drv,
  output logic [DW-1:0] eff
);
  logic [DW-1:0] kept_q;

  always_ff @(posedge clk) begin
    if (rst)          kept_q <= '0;
    else if (pin_drv) kept_q <= pin_in;
  end

  // An undriven port repeats its last driven level
  assign eff = pin_drv ? pin_in : kept_q;
endmodule

// File: rtl/ubt_fall_detect.sv
module ubt_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic cap_clk,
  output logic fall
);
  logic smp_q;
  logic prv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= 1'b0;
      prv_q <= 1'b0;
    end else begin
      smp_q <= cap_clk;
      prv_q <= smp_q;
    end
  end

  // Last sample 0 and the sample before it 1: one-cycle pulse
  assign fall = prv_q & ~smp_q;
endmodule

// File: rtl/ubt_store.sv
module ubt_store #(
  parameter int DW     = 18,
  parameter bit OE_LOW = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          le,
  input  logic          fall,
  input  logic          oe,
  input  logic [DW-1:0] src,
  output logic [DW-1:0] q,
  output logic [DW-1:0] out_d,
  output logic          out_en
);
  logic          en_act;
  logic [DW-1:0] view;

  generate
    if (OE_LOW) begin : g_oe_low
      assign en_act = ~oe;
    end else begin : g_oe_high
      assign en_act = oe;
    end
  endgenerate

  // Transparency wins over a pending edge
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (le)   q <= src;
    else if (fall) q <= src;
  end

  assign view   = le ? src : q;
  assign out_d  = en_act ? view : '0;
  assign out_en = en_act;
endmodule

// File: rtl/ubt_regpath.sv
module ubt_regpath
  import ubt_pkg::*;
#(
  parameter int DW = UBT_DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a_in,
  input  logic          a_drv,
  input  logic [DW-1:0] b_in,
  input  logic          b_drv,
  input  logic          ab_le,
  input  logic          ab_clk,
  input  logic          ab_oe,
  input  logic          ba_le,
  input  logic          ba_clk,
  input  logic          ba_oe_n,
  output logic [DW-1:0] b_out,
  output logic          b_out_en,
  output logic [DW-1:0] a_out,
  output logic          a_out_en
);
  localparam int ND = UBT_NDIR;

  logic [ND-1:0][DW-1:0] pin_v;
  logic [ND-1:0]         drv_v;
  logic [ND-1:0][DW-1:0] src_w;
  logic [ND-1:0]         le_v;
  logic [ND-1:0]         ck_v;
  logic [ND-1:0]         oe_v;
  logic [ND-1:0]         fall_w;
  logic [ND-1:0][DW-1:0] q_w;
  logic [ND-1:0][DW-1:0] od_w;
  logic [ND-1:0]         oen_w;

  // Index DIR_AB sources from A and drives B; DIR_BA the reverse
  assign pin_v[DIR_AB] = a_in;
  assign pin_v[DIR_BA] = b_in;
  assign drv_v[DIR_AB] = a_drv;
  assign drv_v[DIR_BA] = b_drv;
  assign le_v          = {ba_le, ab_le};
  assign ck_v          = {ba_clk, ab_clk};
  assign oe_v          = {ba_oe_n, ab_oe};

  generate
    for (genvar g = 0; g < ND; g++) begin : g_dir
      ubt_bushold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .pin_in  (pin_v[g]),
        .pin_drv (drv_v[g]),
        .eff     (src_w[g])
      );

      ubt_fall_detect u_edge (
        .clk     (clk),
        .rst     (rst),
        .cap_clk (ck_v[g]),
        .fall    (fall_w[g])
      );

      ubt_store #(.DW(DW), .OE_LOW(g == int'(DIR_BA))) u_store (
        .clk    (clk),
        .rst    (rst),
        .le     (le_v[g]),
        .fall   (fall_w[g]),
        .oe     (oe_v[g]),
        .src    (src_w[g]),
        .q      (q_w[g]),
        .out_d  (od_w[g]),
        .out_en (oen_w[g])
      );
    end
  endgenerate

  assign b_out    = od_w[DIR_AB];
  assign b_out_en = oen_w[DIR_AB];
  assign a_out    = od_w[DIR_BA];
  assign a_out_en = oen_w[DIR_BA];
endmodule

// File: rtl/ubt_regpath_chk.sv
module ubt_regpath_chk #(
  parameter int DW = 18
) (
  input logic                clk,
  input logic                rst,
  input logic [DW-1:0]       a_in,
  input logic                a_drv,
  input logic                ab_le,
  input logic                ab_oe,
  input logic                ba_oe_n,
  input logic [DW-1:0]       b_out,
  input logic                b_out_en,
  input logic [DW-1:0]       a_out,
  input logic                a_out_en,
  input logic [1:0]          le_v,
  input logic [1:0]          fall_w,
  input logic [1:0][DW-1:0]  src_w,
  input logic [1:0][DW-1:0]  q_w
);
  a_r2_transparent_ab: assert property (@(posedge clk) disable iff (rst)
    (ab_le && ab_oe && a_drv) |-> (b_out == a_in));

  a_r3_hold_ab: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(le_v[0]) && !$past(fall_w[0])) |-> (q_w[0] == $past(q_w[0])));

  a_r3_hold_ba: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(le_v[1]) && !$past(fall_w[1])) |-> (q_w[1] == $past(q_w[1])));

  a_r4_capture_ab: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(le_v[0]) && $past(fall_w[0])) |-> (q_w[0] == $past(src_w[0])));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fall_w[0] |=> !fall_w[0]);

  a_r6_ab_off: assert property (@(posedge clk) disable iff (rst)
    !ab_oe |-> (!b_out_en && (b_out == '0)));

  a_r7_ba_off: assert property (@(posedge clk) disable iff (rst)
    ba_oe_n |-> (!a_out_en && (a_out == '0)));

  a_r9_bushold_a: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !a_drv) |-> (src_w[0] == $past(src_w[0])));

  a_r10_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> ((q_w[0] == '0) && (q_w[1] == '0)));
endmodule

bind ubt_regpath ubt_regpath_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_in     (a_in),
  .a_drv    (a_drv),
  .ab_le    (ab_le),
  .ab_oe    (ab_oe),
  .ba_oe_n  (ba_oe_n),
  .b_out    (b_out),
  .b_out_en (b_out_en),
  .a_out    (a_out),
  .a_out_en (a_out_en),
  .le_v     (le_v),
  .fall_w   (fall_w),
  .src_w    (src_w),
  .q_w      (q_w)
);

// File: tb/ubt_regpath_tb.sv
module ubt_regpath_tb;
  localparam int DW = 18;

  typedef struct packed {
    logic          dir;
    logic          le;
    logic          ck;
    logic          en;
    logic          drv;
    logic [DW-1:0] d;
    logic          xen;
    logic [DW-1:0] xd;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 20;
  // dir 0 = A-to-B, 1 = B-to-A; en is the logical enable, polarity applied below
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b1,18'h12345,1'b1,18'h12345,4'd2},  // R2
    '{1'b0,1'b1,1'b0,1'b1,1'b1,18'h2AAAA,1'b1,18'h2AAAA,4'd2},  // R2 follows
    '{1'b0,1'b0,1'b0,1'b1,1'b1,18'h00F0F,1'b1,18'h2AAAA,4'd3},  // R3 low
    '{1'b0,1'b0,1'b1,1'b1,1'b1,18'h00F0F,1'b1,18'h2AAAA,4'd5},  // R5 rise
    '{1'b0,1'b0,1'b1,1'b1,1'b1,18'h11111,1'b1,18'h2AAAA,4'd3},  // R3 high
    '{1'b0,1'b0,1'b0,1'b1,1'b1,18'h3C3C3,1'b1,18'h2AAAA,4'd4},  // R4 pending
    '{1'b0,1'b0,1'b0,1'b1,1'b1,18'h0BEEF,1'b1,18'h0BEEF,4'd4},  // R4 load
    '{1'b0,1'b0,1'b0,1'b1,1'b1,18'h15555,1'b1,18'h0BEEF,4'd3},  // R3
    '{1'b0,1'b0,1'b0,1'b0,1'b1,18'h15555,1'b0,18'h00000,4'd6},  // R6 off
    '{1'b0,1'b0,1'b0,1'b1,1'b1,18'h15555,1'b1,18'h0BEEF,4'd8},  // R8
    '{1'b0,1'b1,1'b0,1'b1,1'b1,18'h01234,1'b1,18'h01234,4'd2},  // R2
    '{1'b0,1'b1,1'b0,1'b1,1'b0,18'h3FFFF,1'b1,18'h01234,4'd9},  // R9 hold
    '{1'b1,1'b1,1'b0,1'b1,1'b1,18'h2D2D2,1'b1,18'h2D2D2,4'd2},  // R2 B-to-A
    '{1'b1,1'b0,1'b0,1'b1,1'b1,18'h00001,1'b1,18'h2D2D2,4'd3},  // R3 low
    '{1'b1,1'b0,1'b1,1'b1,1'b1,18'h00001,1'b1,18'h2D2D2,4'd5},  // R5 rise
    '{1'b1,1'b0,1'b1,1'b1,1'b1,18'h0AAAA,1'b1,18'h2D2D2,4'd3},  // R3 high
    '{1'b1,1'b0,1'b0,1'b1,1'b1,18'h00002,1'b1,18'h2D2D2,4'd4},  // R4 pending
    '{1'b1,1'b0,1'b0,1'b1,1'b1,18'h30003,1'b1,18'h30003,4'd4},  // R4 load
    '{1'b1,1'b0,1'b0,1'b0,1'b1,18'h30003,1'b0,18'h00000,4'd7},  // R7 off
    '{1'b1,1'b0,1'b0,1'b1,1'b0,18'h3FFFF,1'b1,18'h30003,4'd8}   // R8 back on
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] a_in = '0, b_in = '0;
  logic          a_drv = 1'b1, b_drv = 1'b1;
  logic          ab_le = 1'b0, ab_clk = 1'b0, ab_oe = 1'b1;
  logic          ba_le = 1'b0, ba_clk = 1'b0, ba_oe_n = 1'b0;
  logic [DW-1:0] b_out, a_out;
  logic          b_out_en, a_out_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ubt_regpath #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_drv(a_drv), .b_in(b_in), .b_drv(b_drv),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_out_en(b_out_en), .a_out(a_out), .a_out_en(a_out_en)
  );

  task automatic chk(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    tick();
    // R10: storage cleared, enables still active
    chk("R10 reset b", {b_out_en, b_out}, {1'b1, 18'h0});
    chk("R10 reset a", {a_out_en, a_out}, {1'b1, 18'h0});

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].dir == 1'b0) begin
        ab_le = TBL[i].le; ab_clk = TBL[i].ck; ab_oe = TBL[i].en;
        a_drv = TBL[i].drv; a_in = TBL[i].d;
      end else begin
        ba_le = TBL[i].le; ba_clk = TBL[i].ck; ba_oe_n = ~TBL[i].en;
        b_drv = TBL[i].drv; b_in = TBL[i].d;
      end
      tick();
      checks++;
      if (TBL[i].dir == 1'b0 ? ({b_out_en, b_out} !== {TBL[i].xen, TBL[i].xd})
                             : ({a_out_en, a_out} !== {TBL[i].xen, TBL[i].xd})) begin
        errors++;
        $display("FAIL row %0d R%0d actual %h expected %h", i, TBL[i].req,
                 TBL[i].dir ? {a_out_en, a_out} : {b_out_en, b_out},
                 {TBL[i].xen, TBL[i].xd});
      end
    end

    // R1: both directions transparent with different data
    ab_le = 1'b1; ab_oe = 1'b1; a_drv = 1'b1; a_in = 18'h15A5A;
    ba_le = 1'b1; ba_oe_n = 1'b0; b_drv = 1'b1; b_in = 18'h2A5A5;
    tick();
    chk("R1 a to b", {b_out_en, b_out}, {1'b1, 18'h15A5A});
    chk("R1 b to a", {a_out_en, a_out}, {1'b1, 18'h2A5A5});

    // R10: reset in mid-run clears storage and held inputs
    ab_le = 1'b0; ba_le = 1'b0; rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R10 mid b", {b_out_en, b_out}, {1'b1, 18'h0});
    chk("R10 mid a", {a_out_en, a_out}, {1'b1, 18'h0});
    ab_le = 1'b1; a_drv = 1'b0; a_in = 18'h3FFFF;
    tick();
    chk("R10 held A cleared (R9)", {b_out_en, b_out}, {1'b1, 18'h0});

    // R6 with transparency: disabled output stays zero
    a_drv = 1'b1; ab_oe = 1'b0;
    tick();
    chk("R6 off transparent", {b_out_en, b_out}, {1'b0, 18'h0});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule